// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Strobe Generator

This block derives a set of four-phase timing strobes from one fast master clock. Four single-phase strobes fire one after another in a fixed rotation. Between any two consecutive phases there is an idle gap in which all four are low. Three merged strobes each cover two neighbouring phases. Each one stays high through its first phase, through the gap that follows, and through its second phase. This keeps precharge-style stages that span two phases stable.

The pulse width and the gap width are each set in master clock cycles. Both are taken at the start of every phase 1, so a rotation already in progress keeps its timing. An enable input starts the rotation. Dropping the enable lets the current rotation finish before the block goes idle. A two-bit phase index follows the active phase, which lets downstream logic check that data moves from one phase to a later one. Every output comes straight from a flop.

Top module: `quad_phase_gen`

## Requirements
- R1: While `rst_n` is low, all of `ph_o`, `mrg_o` and `idx_o` are zero. The block then stays idle until `en` is seen high.
- R2: When `en` is sampled high in idle, `ph_o` becomes 4'b0001 (phase 1, bit 0) on that same clock edge, and `idx_o` reads 0.
- R3: Single phases run in the order bit 0, bit 1, bit 2, bit 3, then bit 0 again. `idx_o` holds k while phase bit k is active and during the gap that follows it. `idx_o` only ever changes to its old value plus one, modulo 4.
- R4: At most one bit of `ph_o` is high in any cycle.
- R5: Each single-phase pulse lasts `pulse_len`+1 master cycles.
- R6: After each single phase, including phase 4 before the next phase 1, all bits of `ph_o` are low for `gap_len`+1 cycles.
- R7: `mrg_o[m]` (m = 0, 1, 2) is high exactly during phase bit m, the gap that follows it, and phase bit m+1. It is low at every other time.
- R8: `pulse_len` and `gap_len` are taken only in the cycle that a phase 1 begins. Changing them at any other time has no effect until the next rotation.
- R9: If `en` is low when the gap after phase 4 ends, the block goes idle with all strobes low and stays idle until `en` is high. Dropping `en` earlier does not cut short the rotation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Run request |
| pulse_len | input | PW | Single-phase width minus one, in master cycles |
| gap_len | input | GW | Non-overlap gap width minus one, in master cycles |
| ph_o | output | 4 | Single-phase strobes; bit 0 is phase 1 |
| mrg_o | output | 3 | Merged strobes; bit m spans phases m+1 and m+2 |
| idx_o | output | 2 | Index of the active or most recent phase |

## Verification
There are two collisions to cover.

The first is the gap after phase 4 expiring in the same cycle that the enable is examined. That cycle also reloads the widths and restarts phase 1. The bench provokes it with the enable both held high and dropped, and with the widths changed in the middle of the earlier rotation. It judges the result by whether the next rotation runs with the new widths or the block goes idle.

The second is a merged strobe's end falling in the same cycle as the next merged strobe's start. The bench runs minimum and random widths and compares every cycle of every segment against the expected strobe pattern.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
  localparam int NUM_PH  = 4;
  localparam int IDX_W   = $clog2(NUM_PH);
  localparam int NUM_MRG = NUM_PH - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } qpg_state_e;
endpackage

// File: rtl/qpg_seq.sv
module qpg_seq
  import qpg_pkg::*;
#(
  parameter int PW = 4,
  parameter int GW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PW-1:0]    pulse_len,
  input  logic [GW-1:0]    gap_len,
  output qpg_state_e       state_d,
  output logic [IDX_W-1:0] idx_d,
  output logic [IDX_W-1:0] idx_q
);
  localparam int CW = (PW > GW) ? PW : GW;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PH - 1);

  qpg_state_e     state_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PW-1:0]  plen_q;
  logic [GW-1:0]  glen_q;
  logic           lat_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    lat_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          state_d = ST_PULSE;
          idx_d   = '0;
          cnt_d   = CW'(pulse_len);
          lat_en  = 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin
          state_d = ST_GAP;
          cnt_d   = CW'(glen_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (idx_q != LAST) begin
          state_d = ST_PULSE;
          idx_d   = idx_q + 1'b1;
          cnt_d   = CW'(plen_q);
        end else if (en) begin
          state_d = ST_PULSE;
          idx_d   = '0;
          cnt_d   = CW'(pulse_len);
          lat_en  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  // width capture, enabled only at phase-1 start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen_q <= '0;
      glen_q <= '0;
    end else if (lat_en) begin
      plen_q <= pulse_len;
      glen_q <= gap_len;
    end
  end
endmodule

// File: rtl/qpg_decode.sv
module qpg_decode
  import qpg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  qpg_state_e         state_d,
  input  logic [IDX_W-1:0]   idx_d,
  output logic [NUM_PH-1:0]  ph_q,
  output logic [NUM_MRG-1:0] mrg_q
);
  logic [NUM_PH-1:0]  ph_d;
  logic [NUM_MRG-1:0] mrg_d;
  logic               in_pulse, in_gap;

  assign in_pulse = (state_d == ST_PULSE);
  assign in_gap   = (state_d == ST_GAP);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    assign ph_d[k] = in_pulse && (idx_d == IDX_W'(k));
  end

  for (genvar m = 0; m < NUM_MRG; m++) begin : g_mrg
    assign mrg_d[m] = (in_pulse && ((idx_d == IDX_W'(m)) || (idx_d == IDX_W'(m + 1))))
                   || (in_gap && (idx_d == IDX_W'(m)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mrg_q <= '0;
    end else begin
      ph_q  <= ph_d;
      mrg_q <= mrg_d;
    end
  end
endmodule

// File: rtl/quad_phase_gen.sv
module quad_phase_gen
  import qpg_pkg::*;
#(
  parameter int PW = 4,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] pulse_len,
  input  logic [GW-1:0] gap_len,
  output logic [3:0]    ph_o,
  output logic [2:0]    mrg_o,
  output logic [1:0]    idx_o
);
  qpg_state_e       state_d;
  logic [IDX_W-1:0] idx_d;

  qpg_seq #(.PW(PW), .GW(GW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pulse_len (pulse_len),
    .gap_len   (gap_len),
    .state_d   (state_d),
    .idx_d     (idx_d),
    .idx_q     (idx_o)
  );

  qpg_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .idx_d   (idx_d),
    .ph_q    (ph_o),
    .mrg_q   (mrg_o)
  );
endmodule

// File: rtl/qpg_chk.sv
module qpg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ph,
  input logic [2:0] mrg,
  input logic [1:0] idx
);
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ph));

  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> (idx == 2'($past(idx) + 2'd1)));

  for (genvar k = 0; k < 4; k++) begin : g_ph
    a_r6_gap_after: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ph[k]) |-> (ph == 4'b0000));
    a_r3_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
      ph[k] |-> (idx == 2'(k)));
  end

  for (genvar k = 1; k < 4; k++) begin : g_ord
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph[k]) |-> ($past(idx) == 2'(k - 1)) && ($past(ph) == 4'b0000));
  end

  for (genvar m = 0; m < 3; m++) begin : g_mrg
    a_r7_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (ph[m] || ph[m+1]) |-> mrg[m]);
    a_r7_only: assert property (@(posedge clk) disable iff (!rst_n)
      mrg[m] |-> ((ph & ~(4'b0011 << m)) == 4'b0000));
    a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mrg[m]) |-> $past(ph[m+1]));
  end
endmodule

bind quad_phase_gen qpg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ph    (ph_o),
  .mrg   (mrg_o),
  .idx   (idx_o)
);

// File: tb/sim_quad_phase_gen.sv
`timescale 1ns/1ps
module sim_quad_phase_gen;
  logic       clk = 1'b0;
  logic       rst_n, en;
  logic [3:0] pulse_len, gap_len;
  logic [3:0] ph_o;
  logic [2:0] mrg_o;
  logic [1:0] idx_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pulse_len(pulse_len), .gap_len(gap_len),
    .ph_o(ph_o), .mrg_o(mrg_o), .idx_o(idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // merged pattern: pulse k -> bits k-1 and k; gap after k -> bit k
  function automatic logic [2:0] exp_mrg(input int k, input bit gap);
    logic [2:0] r = '0;
    for (int m = 0; m < 3; m++) begin
      if (!gap && (k == m || k == m + 1)) r[m] = 1'b1;
      if (gap && k == m) r[m] = 1'b1;
    end
    return r;
  endfunction

  function automatic int pack(input logic [1:0] i, input logic [2:0] m, input logic [3:0] p);
    return int'({i, m, p});
  endfunction

  // caller is at the first sample of phase 1; returns at the sample after the last gap
  task automatic expect_rotation(input int p, input int g, input string tag);
    for (int k = 0; k < 4; k++) begin
      bit ok = 1'b1; int act = 0; int exp = 0;
      for (int i = 0; i <= p; i++) begin
        exp = pack(2'(k), exp_mrg(k, 1'b0), 4'(1 << k));
        if (pack(idx_o, mrg_o, ph_o) != exp && ok) begin ok = 1'b0; act = pack(idx_o, mrg_o, ph_o); end
        @(negedge clk);
      end
      chk(ok, {tag, " R3 R4 R5 R7 pulse"}, act, exp);
      ok = 1'b1;
      for (int i = 0; i <= g; i++) begin
        exp = pack(2'(k), exp_mrg(k, 1'b1), 4'b0000);
        if (pack(idx_o, mrg_o, ph_o) != exp && ok) begin ok = 1'b0; act = pack(idx_o, mrg_o, ph_o); end
        @(negedge clk);
      end
      chk(ok, {tag, " R6 R7 gap"}, act, exp);
    end
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit ok = 1'b1; int act = 0;
    for (int i = 0; i < n; i++) begin
      if ({mrg_o, ph_o} != 7'd0 && ok) begin ok = 1'b0; act = int'({mrg_o, ph_o}); end
      @(negedge clk);
    end
    chk(ok, {tag, " R9 idle"}, act, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; pulse_len = '0; gap_len = '0;
    repeat (3) @(negedge clk);
    chk(pack(idx_o, mrg_o, ph_o) == 0, "R1 reset", pack(idx_o, mrg_o, ph_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle(4, "R1");
  endtask

  task automatic t_min_widths();
    pulse_len = 4'd0; gap_len = 4'd0; en = 1'b1;
    chk(ph_o == 4'b0000, "R2 before edge", ph_o, 0);
    @(negedge clk);
    chk(ph_o == 4'b0001 && idx_o == 2'd0, "R2 first phase", pack(idx_o, mrg_o, ph_o), 1);
    en = 1'b0;
    expect_rotation(0, 0, "min");
    expect_idle(3, "min");
  endtask

  task automatic t_resample();
    pulse_len = 4'd1; gap_len = 4'd0; en = 1'b1;
    @(negedge clk);
    pulse_len = 4'd3; gap_len = 4'd2;  // R8: must not touch this rotation
    expect_rotation(1, 0, "R8 old");
    en = 1'b0;                          // next rotation already started
    expect_rotation(3, 2, "R8 new");
    expect_idle(5, "R8");
  endtask

  task automatic t_early_drop();
    pulse_len = 4'd2; gap_len = 4'd1; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    pulse_len = 4'd7;
    expect_rotation(2, 1, "R9 drop");
    expect_idle(6, "R9 drop");
  endtask

  task automatic t_random();
    for (int r = 0; r < 8; r++) begin
      int p = $urandom_range(0, 15);
      int g = $urandom_range(0, 15);
      pulse_len = 4'(p); gap_len = 4'(g); en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      expect_rotation(p, g, "rand");
      expect_idle(2, "rand");
    end
  endtask

  task automatic t_reset_mid();
    pulse_len = 4'd4; gap_len = 4'd3; en = 1'b1;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pack(idx_o, mrg_o, ph_o) == 0, "R1 mid reset", pack(idx_o, mrg_o, ph_o), 0);
    @(negedge clk);
    en = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    expect_idle(4, "R1 after");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_min_widths();
    t_resample();
    t_early_drop();
    t_random();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule